// File: doc/BRIEF.md
# Register-Staged Byte Memory

This block is a byte-wide memory that outside logic never reaches directly. Every access passes through two staging registers: an address register (MAR) and a data register (MDR). The caller picks fetch or store on `fs_sel`, presents an address (and a byte for a store), and pulses `start`. A small sequencer then runs the access one step per clock cycle. It latches the address, latches the byte for a store, registers a one-hot row select decoded from the address, and moves the byte between the selected cell and the MDR. A one-cycle `done` pulse closes the access. After a fetch, `mdr_out` holds the byte that was read. After a store, it holds the byte that was written.

The sequencer has these states:
- `ST_IDLE`: waits for `start`.
- `ST_MAR`: loads the MAR.
- `ST_MDR`: loads the MDR. Stores only.
- `ST_DEC`: registers the decoded row select.
- `ST_XFER`: copies cell to MDR, or MDR to cell.
- `ST_DONE`: raises `done`.

It has these transitions:
- `ST_IDLE`→`ST_MAR` when `start` is sampled high.
- `ST_MAR`→`ST_MDR` for a store, or `ST_MAR`→`ST_DEC` for a fetch.
- `ST_MDR`→`ST_DEC`.
- `ST_DEC`→`ST_XFER`.
- `ST_XFER`→`ST_DONE`.
- `ST_DONE`→`ST_IDLE`.

Top module: `staged_mem_unit`

## Requirements
- R1: While reset is active, and on the first edge after it, the MAR and MDR read zero, `mdr_out` is 0, `done` is low and the sequencer is idle. Reset does not clear the memory cells.
- R2: With `ADDR_W` address bits there are 2^ADDR_W cells of 8 bits, addressed 0 to 2^ADDR_W−1. Cell 0 and the top cell are independent storage.
- R3: A fetch (`fs_sel`=0 when `start` is sampled) goes through `ST_MAR`, `ST_DEC`, `ST_XFER`. `done` is high in the cycle after the third rising edge following the edge that sampled `start`, and `mdr_out` then holds the addressed cell.
- R4: A store (`fs_sel`=1 when `start` is sampled) goes through `ST_MAR`, `ST_MDR`, `ST_DEC`, `ST_XFER`. `done` is high in the cycle after the fourth rising edge following the edge that sampled `start`, and `mdr_out` then holds the stored byte.
- R5: A fetch leaves the cell unchanged, so repeated fetches return the same byte.
- R6: A store replaces the previous contents of the addressed cell.
- R7: `fs_sel` is read only on the edge that accepts `start` and selects the operation for the whole sequence.
- R8: `done` is high for exactly one cycle per operation.
- R9: `start` is ignored in every state other than `ST_IDLE`, including the `done` cycle. No extra operation runs, no extra `done` appears and no cell is written.
- R10: Between operations, `mdr_out` keeps the value it had when `done` was high.
- R11: The address is sampled at the edge leaving `ST_MAR` and the store byte at the edge leaving `ST_MDR`. The MAR is unchanged from the decode step through the transfer step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| fs_sel | input | 1 | Operation select: 0 fetch, 1 store |
| addr_in | input | ADDR_W | Cell address, held until `done` |
| data_in | input | 8 | Byte to store, held until `done` |
| done | output | 1 | One-cycle end-of-operation pulse |
| mdr_out | output | 8 | Contents of the data register |

## Verification
The bound checker watches, on every cycle:
- that `done` never lasts past one cycle;
- that each transfer step is followed at once by `done`;
- that the row select is one-hot whenever a transfer happens;
- that the MAR holds from decode through transfer;
- that the MDR holds across the cycle after `done`.

Only the bench's scenarios can show the end-to-end results. These are the two latencies counted from the `start` edge, the byte values returned, that fetches do not disturb cells, that stores overwrite them, and that `start` pulses landing mid-sequence or on the `done` cycle leave the memory untouched.

// File: rtl/smu_pkg.sv
package smu_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MAR  = 3'd1,
        ST_MDR  = 3'd2,
        ST_DEC  = 3'd3,
        ST_XFER = 3'd4,
        ST_DONE = 3'd5
    } smu_state_e;

endpackage

// File: rtl/smu_seq.sv
module smu_seq
    import smu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fs_sel,
    output logic ld_mar,
    output logic ld_mdr,
    output logic dec_en,
    output logic rd_xfer,
    output logic wr_xfer,
    output logic done
);

    smu_state_e state_q;
    smu_state_e state_d;
    logic       is_store_q;

    // state register, with the operation latched on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            is_store_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                is_store_q <= fs_sel;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_MAR;
            ST_MAR:  state_d = is_store_q ? ST_MDR : ST_DEC;
            ST_MDR:  state_d = ST_DEC;
            ST_DEC:  state_d = ST_XFER;
            ST_XFER: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // step strobes
    always_comb begin
        ld_mar  = 1'b0;
        ld_mdr  = 1'b0;
        dec_en  = 1'b0;
        rd_xfer = 1'b0;
        wr_xfer = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MAR:  ld_mar = 1'b1;
            ST_MDR:  ld_mdr = 1'b1;
            ST_DEC:  dec_en = 1'b1;
            ST_XFER: begin
                rd_xfer = !is_store_q;
                wr_xfer = is_store_q;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/smu_regs.sv
module smu_regs
    import smu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_mar,
    input  logic              ld_mdr,
    input  logic              rd_xfer,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mar,
    output logic [BYTE_W-1:0] mdr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
        end else if (ld_mar) begin
            mar <= addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr <= '0;
        end else if (ld_mdr) begin
            mdr <= data_in;
        end else if (rd_xfer) begin
            mdr <= rd_data;
        end
    end

endmodule

// File: rtl/smu_cells.sv
module smu_cells
    import smu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dec_en,
    input  logic                     wr_xfer,
    input  logic [ADDR_W-1:0]        mar,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [(1<<ADDR_W)-1:0]   row_sel
);

    localparam int NCELL = 1 << ADDR_W;

    logic [BYTE_W-1:0] cell_q [NCELL];

    for (genvar gi = 0; gi < NCELL; gi++) begin : g_row
        // registered one-hot decode of the MAR
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_sel[gi] <= 1'b0;
            end else if (dec_en) begin
                row_sel[gi] <= (mar == ADDR_W'(gi));
            end
        end

        // storage cell, not cleared by reset
        always_ff @(posedge clk) begin
            if (wr_xfer && row_sel[gi]) begin
                cell_q[gi] <= wr_data;
            end
        end
    end

    // one-hot read mux
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCELL; i++) begin
            if (row_sel[i]) begin
                rd_data = rd_data | cell_q[i];
            end
        end
    end

endmodule

// File: rtl/staged_mem_unit.sv
module staged_mem_unit
    import smu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fs_sel,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    output logic              done,
    output logic [7:0]        mdr_out
);

    localparam int NCELL = 1 << ADDR_W;

    logic              ld_mar;
    logic              ld_mdr;
    logic              dec_en;
    logic              rd_xfer;
    logic              wr_xfer;
    logic [ADDR_W-1:0] mar;
    logic [BYTE_W-1:0] mdr;
    logic [BYTE_W-1:0] rd_data;
    logic [NCELL-1:0]  row_sel;

    smu_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .fs_sel  (fs_sel),
        .ld_mar  (ld_mar),
        .ld_mdr  (ld_mdr),
        .dec_en  (dec_en),
        .rd_xfer (rd_xfer),
        .wr_xfer (wr_xfer),
        .done    (done)
    );

    smu_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_mar  (ld_mar),
        .ld_mdr  (ld_mdr),
        .rd_xfer (rd_xfer),
        .addr_in (addr_in),
        .data_in (data_in),
        .rd_data (rd_data),
        .mar     (mar),
        .mdr     (mdr)
    );

    smu_cells #(.ADDR_W(ADDR_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_en  (dec_en),
        .wr_xfer (wr_xfer),
        .mar     (mar),
        .wr_data (mdr),
        .rd_data (rd_data),
        .row_sel (row_sel)
    );

    assign mdr_out = mdr;

endmodule

// File: rtl/smu_chk.sv
module smu_chk #(
    parameter int ADDR_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   done,
    input logic                   rd_xfer,
    input logic                   wr_xfer,
    input logic [ADDR_W-1:0]      mar,
    input logic [7:0]             mdr,
    input logic [(1<<ADDR_W)-1:0] row_sel
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (mar == '0 && mdr == '0 && !done));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    fetch_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_xfer |=> done);

    // R4
    store_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_xfer |=> done);

    // R2
    one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_xfer || wr_xfer) |-> $onehot(row_sel));

    // R11
    mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_xfer || wr_xfer) |-> $stable(mar));

    // R10
    mdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(mdr));

endmodule

bind staged_mem_unit smu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .rd_xfer (rd_xfer),
    .wr_xfer (wr_xfer),
    .mar     (mar),
    .mdr     (mdr),
    .row_sel (row_sel)
);

// File: tb/staged_mem_unit_test.sv
`timescale 1ns/1ps
module staged_mem_unit_test;

    localparam int AW    = 4;
    localparam int NCELL = 1 << AW;

    typedef struct {
        logic [7:0] exp_data;
        int         exp_lat;
        int         start_cyc;
        bit         is_store;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          fs_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    data_in = '0;
    logic          done;
    logic [7:0]    mdr_out;

    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    bit   finished = 1'b0;
    bit   done_prev = 1'b0;
    logic [7:0] shadow [NCELL];
    exp_t sb_q [$];

    always #2 clk = ~clk;

    staged_mem_unit #(.ADDR_W(AW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .fs_sel  (fs_sel),
        .addr_in (addr_in),
        .data_in (data_in),
        .done    (done),
        .mdr_out (mdr_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected items when done appears
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done) begin
                check(!done_prev, "R8 done longer than one cycle", 1, 0);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9 done without accepted start", 1, 0);
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check(mdr_out == it.exp_data,
                          it.is_store ? "R4/R6 store data" : "R3/R5 fetch data",
                          mdr_out, it.exp_data);
                    check((cyc - it.start_cyc) == it.exp_lat,
                          it.is_store ? "R4 store latency" : "R3 fetch latency",
                          cyc - it.start_cyc, it.exp_lat);
                end
            end
            done_prev = done;
        end
    end

    // driver: noise_mid pulses start inside the sequence, noise_done on the done cycle
    task automatic run_op(bit st, int a, logic [7:0] d,
                          bit noise_mid, bit noise_done, int na);
        exp_t it;
        @(negedge clk);
        start   = 1'b1;
        fs_sel  = st;
        addr_in = AW'(a);
        data_in = d;
        it.is_store  = st;
        it.exp_lat   = st ? 4 : 3;
        it.start_cyc = cyc + 1;
        it.exp_data  = st ? d : shadow[a];
        if (st) shadow[a] = d;
        sb_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        if (noise_mid) begin
            repeat (st ? 2 : 1) @(negedge clk);
            start   = 1'b1;
            fs_sel  = 1'b1;
            addr_in = AW'(na);
            data_in = 8'hEE;
            @(negedge clk);
            start = 1'b0;
        end
        wait (sb_q.size() == 0);
        if (noise_done) begin
            start   = 1'b1;
            fs_sel  = 1'b1;
            addr_in = AW'(na);
            data_in = 8'hDD;
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mdr_out == 8'h00, "R1 mdr_out in reset", mdr_out, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mdr_out == 8'h00 && done == 1'b0, "R1 state after reset", mdr_out, 0);

        // R2 R4 fill every cell, including address 0 and the top
        for (int i = 0; i < NCELL; i++) begin
            run_op(1'b1, i, 8'(8'h30 + i * 7), 1'b0, 1'b0, 0);
        end
        // R3 R5 read back everything, twice
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < NCELL; i++) begin
                run_op(1'b0, i, 8'h00, 1'b0, 1'b0, 0);
            end
        end
        // R2 R6 overwrite edge cells and confirm neighbours untouched
        run_op(1'b1, 0, 8'hA5, 1'b0, 1'b0, 0);
        run_op(1'b1, NCELL - 1, 8'h5A, 1'b0, 1'b0, 0);
        run_op(1'b0, 0, 8'h00, 1'b0, 1'b0, 0);
        run_op(1'b0, 1, 8'h00, 1'b0, 1'b0, 0);
        run_op(1'b0, NCELL - 1, 8'h00, 1'b0, 1'b0, 0);
        run_op(1'b0, NCELL - 2, 8'h00, 1'b0, 1'b0, 0);
        run_op(1'b1, 5, 8'hFF, 1'b0, 1'b0, 0);
        run_op(1'b1, 5, 8'h00, 1'b0, 1'b0, 0);
        run_op(1'b0, 5, 8'h00, 1'b0, 1'b0, 0);

        // R10 mdr_out holds between operations
        repeat (4) @(negedge clk);
        check(mdr_out == shadow[5], "R10 mdr_out held while idle", mdr_out, shadow[5]);

        // R7 R9 start pulses while busy are ignored
        run_op(1'b0, 3, 8'h00, 1'b1, 1'b0, 9);
        run_op(1'b1, 4, 8'h77, 1'b1, 1'b0, 10);
        run_op(1'b0, 6, 8'h00, 1'b0, 1'b1, 11);
        repeat (6) @(negedge clk);
        check(sb_q.size() == 0 && done == 1'b0, "R9 no extra operation", done, 0);
        run_op(1'b0, 9, 8'h00, 1'b0, 1'b0, 0);
        run_op(1'b0, 10, 8'h00, 1'b0, 1'b0, 0);
        run_op(1'b0, 11, 8'h00, 1'b0, 1'b0, 0);
        run_op(1'b0, 4, 8'h00, 1'b0, 1'b0, 0);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule